// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter

This block is the central arbiter for a shared bus used by a fixed number of masters. Each master has its own request wire and its own grant wire. The arbiter hands the bus to one master at a time. That master keeps the bus until a release input reports that it has finished. Only then is the bus free for the next grant.

Requests are re-timed through a two-flop synchronizer before the arbiter acts on them. Priority among the pending masters is circular. A one-hot pointer marks the master that currently ranks highest, and a fixed-priority chain scans upward from that mark and wraps around. When an owner gives up the bus, the pointer moves to the master just after it. The master that was just served therefore ranks lowest on the next round, and no master can be locked out indefinitely.

Top module: `rotary_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted and master 0 ranks highest.
- R2: At most one grant bit is high in any cycle.
- R3: A request seen by the synchronizer at a rising edge is not visible to arbitration until two edges later. On an idle bus a request first present before edge t is granted at edge t+2, and the grant is still low after edge t+1.
- R4: Once issued, a grant stays high and unchanged until release is seen, whatever the request lines do in the meantime.
- R5: Release sampled high while a grant is active clears the grant at that edge, so the bus is idle for at least one cycle between owners.
- R6: When master k gives up the bus, master (k+1) mod N ranks highest. Among pending masters, the first one met going upward from that index, wrapping from N-1 to 0, is the winner. The pointer is always one-hot.
- R7: Release while no grant is active has no effect, and the priority pointer does not move while the bus is idle.
- R8: A grant is issued only to a master whose synchronized request is high.
- R9: An idle bus with at least one synchronized request issues a grant at the next edge.
- R10: With all masters requesting continuously and each owner releasing in turn, grants visit the masters in ascending circular order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| req_i | input | N_UNITS | One request line per master |
| release_i | input | 1 | Current owner is done with the bus |
| grant_o | output | N_UNITS | One grant line per master, at most one high |

## Verification
The checks assume that release is pulsed only by the master that owns the bus, or else while the bus is idle, where it must have no effect. They also assume that each request stays high long enough to pass the synchronizer. The stimulus holds every request steady for at least three edges before it looks for a grant. It withdraws a request and waits until the synchronizer has emptied before it pulses release, so that a stale request cannot cause a regrant. Under those conditions the bench sweeps every nonzero request mask against every pointer position and predicts each winner by plain circular index arithmetic.

// File: rtl/rotary_arb_pkg.sv
package rotary_arb_pkg;
  localparam int unsigned DEF_UNITS       = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [0:0] {
    BUS_IDLE  = 1'b0,
    BUS_OWNED = 1'b1
  } bus_phase_e;
endpackage

// File: rtl/arb_req_sync.sv
module arb_req_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/arb_ring_pointer.sv
module arb_ring_pointer #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  logic [WIDTH-1:0] owner_i,
  output logic [WIDTH-1:0] top_o
);
  function automatic logic [WIDTH-1:0] rotate_up(input logic [WIDTH-1:0] v);
    return {v[WIDTH-2:0], v[WIDTH-1]};
  endfunction

  logic [WIDTH-1:0] top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) top_q <= {{(WIDTH-1){1'b0}}, 1'b1};
    else if (advance_i) top_q <= rotate_up(owner_i);
  end

  assign top_o = top_q;
endmodule

// File: rtl/arb_priority_pick.sv
module arb_priority_pick #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] req_i,
  input  logic [WIDTH-1:0] top_i,
  output logic [WIDTH-1:0] pick_o
);
  localparam int unsigned DW = 2 * WIDTH;

  function automatic logic [DW-1:0] lowest_set(input logic [DW-1:0] v);
    return v & (~v + {{(DW-1){1'b0}}, 1'b1});
  endfunction

  logic [WIDTH-1:0] at_or_above;
  logic [DW-1:0]    doubled;
  logic [DW-1:0]    first_hit;

  assign at_or_above = ~(top_i - {{(WIDTH-1){1'b0}}, 1'b1});
  assign doubled     = {req_i, req_i & at_or_above};
  assign first_hit   = lowest_set(doubled);
  assign pick_o      = first_hit[WIDTH-1:0] | first_hit[DW-1:WIDTH];
endmodule

// File: rtl/rotary_bus_arbiter.sv
module rotary_bus_arbiter
  import rotary_arb_pkg::*;
#(
  parameter int unsigned N_UNITS     = DEF_UNITS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] req_i,
  input  logic               release_i,
  output logic [N_UNITS-1:0] grant_o
);
  logic [N_UNITS-1:0] sreq;
  logic [N_UNITS-1:0] top_ptr;
  logic [N_UNITS-1:0] winner;
  logic [N_UNITS-1:0] grant_q;
  bus_phase_e         phase;
  logic               busy;
  logic               rel_evt;
  logic               issue_evt;

  arb_req_sync #(.WIDTH(N_UNITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(req_i), .sync_o(sreq)
  );

  arb_ring_pointer #(.WIDTH(N_UNITS)) u_ring (
    .clk(clk), .rst_n(rst_n), .advance_i(rel_evt),
    .owner_i(grant_q), .top_o(top_ptr)
  );

  arb_priority_pick #(.WIDTH(N_UNITS)) u_pick (
    .req_i(sreq), .top_i(top_ptr), .pick_o(winner)
  );

  assign busy      = |grant_q;
  assign phase     = busy ? BUS_OWNED : BUS_IDLE;
  assign rel_evt   = (phase == BUS_OWNED) && release_i;
  assign issue_evt = (phase == BUS_IDLE) && (|sreq);

  always_ff @(posedge clk) begin
    if (!rst_n) grant_q <= '0;
    else if (rel_evt) grant_q <= '0;
    else if (issue_evt) grant_q <= winner;
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/rotary_bus_arbiter_checker.sv
module rotary_bus_arbiter_checker #(
  parameter int unsigned N_UNITS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               release_i,
  input logic [N_UNITS-1:0] grant_o,
  input logic [N_UNITS-1:0] top_ptr,
  input logic [N_UNITS-1:0] sreq,
  input logic               busy,
  input logic               rel_evt,
  input logic               issue_evt
);
  logic [2*N_UNITS-1:0] g_dbl;
  logic [N_UNITS-1:0]   g_next;
  assign g_dbl  = {grant_o, grant_o};
  assign g_next = g_dbl[2*N_UNITS-2 : N_UNITS-1];

  AST_ONE_GRANT:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o)); // R2
  AST_PTR_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot(top_ptr)); // R6
  AST_HOLD_GRANT:   assert property (@(posedge clk) disable iff (!rst_n)
                      (|grant_o && !release_i) |=> (grant_o == $past(grant_o))); // R4
  AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
                      (|grant_o && release_i) |=> (grant_o == '0)); // R5
  AST_PTR_ADVANCE:  assert property (@(posedge clk) disable iff (!rst_n)
                      (|grant_o && release_i) |=> (top_ptr == $past(g_next))); // R6
  AST_PTR_STILL:    assert property (@(posedge clk) disable iff (!rst_n)
                      !rel_evt |=> $stable(top_ptr)); // R7
  AST_GRANT_WANTED: assert property (@(posedge clk) disable iff (!rst_n)
                      (!busy && |sreq) |=> ((grant_o & $past(sreq)) != '0)); // R8
  AST_IDLE_SERVES:  assert property (@(posedge clk) disable iff (!rst_n)
                      issue_evt |=> (|grant_o)); // R9
endmodule

bind rotary_bus_arbiter rotary_bus_arbiter_checker #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .release_i(release_i), .grant_o(grant_o),
  .top_ptr(top_ptr), .sreq(sreq), .busy(busy), .rel_evt(rel_evt),
  .issue_evt(issue_evt)
);

// File: tb/rotary_bus_arbiter_test.sv
module rotary_bus_arbiter_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         release_i = 1'b0;
  logic [N-1:0] grant_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int model_top = 0;

  always #2.5 clk = ~clk;

  rotary_bus_arbiter #(.N_UNITS(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .release_i(release_i), .grant_o(grant_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int winner_of(input int mask, input int top);
    for (int o = 0; o < N; o++) begin
      if (mask[(top + o) % N]) return (top + o) % N;
    end
    return -1;
  endfunction

  task automatic pulse_release();
    release_i = 1'b1;
    tick(1);
    release_i = 1'b0;
  endtask

  // grant one mask, confirm, withdraw, hold, release
  task automatic serve(input int mask, input bit full);
    int w;
    w = winner_of(mask, model_top);
    req_i = mask[N-1:0];
    tick(2);
    if (full) check(grant_o == '0, "R3 early", int'(grant_o), 0);
    tick(1);
    check(grant_o == N'(1 << w), "R6 winner", int'(grant_o), 1 << w);
    if (full) check((grant_o & mask[N-1:0]) != '0, "R8 requested", int'(grant_o), mask);
    req_i = '0;
    tick(3);
    if (full) check(grant_o == N'(1 << w), "R4 hold", int'(grant_o), 1 << w);
    pulse_release();
    check(grant_o == '0, "R5 drop", int'(grant_o), 0);
    model_top = (w + 1) % N;
  endtask

  initial begin
    int w;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(grant_o == '0, "R1 reset grant", int'(grant_o), 0);
    serve(4'hF, 1'b1);
    check(model_top == 1, "R1 top after reset", model_top, 1);

    for (int p = 0; p < N; p++) begin
      for (int m = 1; m < (1 << N); m++) begin
        serve(1 << ((p + N - 1) % N), 1'b0);
        serve(m, 1'b1);
      end
    end

    // R7: idle release does not move pointer
    serve(1 << 1, 1'b0);
    pulse_release();
    check(grant_o == '0, "R7 idle release", int'(grant_o), 0);
    tick(4);
    serve(4'hF, 1'b1);
    check(model_top == 3, "R7 pointer kept", model_top, 3);

    // R9 / R10: continuous requests rotate through all masters
    req_i = 4'hF;
    tick(3);
    w = winner_of(15, model_top);
    check(grant_o == N'(1 << w), "R9 first", int'(grant_o), 1 << w);
    for (int k = 0; k < 2 * N; k++) begin
      pulse_release();
      check(grant_o == '0, "R5 gap", int'(grant_o), 0);
      tick(1);
      w = (w + 1) % N;
      check(grant_o == N'(1 << w), "R10 rotation", int'(grant_o), 1 << w);
      check($countones(grant_o) <= 1, "R2 single", $countones(grant_o), 1);
    end
    req_i = '0;
    tick(3);
    pulse_release();

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule